// File: doc/BRIEF.md
# Trigger Sequence Emulator

This block stands in for the central trigger when front-end electronics must be exercised on their own. It plays back a short list of trigger sequences held in a small program store. Each entry names one of seven legal shapes built from a pre-pulse, a level-0 strobe, a level-1 strobe and a final level-2 decision (accept or reject). Each entry also carries its own level-1 and level-2 data words. Every strobe falls at a fixed number of bunch-crossing clocks after the start slot. A level-1 rejection is expressed only by leaving out the level-1 strobe.

Playback of the next entry is triggered by one of four selectable sources: a downscaled bunch-crossing count, a pseudo-random generator compared against a threshold, the rising edge of an external pulser, or a software request. A start that arrives while the detector reports busy, or while a sequence is still in flight, is discarded and tallied. For recovery testing, selected entries can be corrupted while the error mode is on, and a one-shot request corrupts the next sequence whatever its entry says.

Top module: `trig_seq_emu`

## Requirements
- R1: After reset all five strobes are low, the drop count is zero and the first sequence played comes from entry 0.
- R2: The three-bit entry code selects the strobes. 0 gives L0. 1 gives L0, L1, L2-accept. 2 gives L0, L1, L2-reject. 3 gives pre-pulse alone. 4 gives pre-pulse, L0. 5 gives pre-pulse, L0, L1, L2-accept. 6 gives pre-pulse, L0, L1, L2-reject. Code 7 emits nothing, is not counted as a drop and still moves to the next entry. At most one strobe is high in any cycle.
- R3: Taking the start slot as cycle 0, the pre-pulse appears in cycle 0, L0 in cycle L0_LAT, L1 in cycle L1_LAT and L2 in cycle L2_LAT. A software request sampled at a clock edge puts the start slot two edges after it, and every L2 follows its L1 by exactly L2_LAT-L1_LAT cycles.
- R4: The entry's level-1 word is on `l1_data_o` while L1 is high, and its level-2 word is on `l2_data_o` while either L2 strobe is high.
- R5: With source 3 selected, a pulse on `sw_req` starts the next entry. While `run` is low no source starts anything, and the program pointer does not move.
- R6: With source 0 selected, starts occur every `ds_period`+1 cycles.
- R7: With source 2 selected, only a rising edge of `pulser` starts a sequence. Holding it high starts exactly one.
- R8: With source 1 selected, a threshold of 0 never starts a sequence and a threshold of 255 does.
- R9: A start that arrives while `busy_in` is high produces no strobes, adds one to the drop count and does not move the program pointer.
- R10: A start that arrives while a sequence is active is dropped and counted, so no L0 falls between an L0 and its L1.
- R11: After entry `prog_last` has been played, the pointer returns to entry 0.
- R12: A pulse on `force_err` corrupts the next valid sequence only. A corrupted sequence that contains L1 loses its L2. A corrupted sequence without L1 gains a stray L1, carrying the entry's level-1 word, in cycle L1_LAT.
- R13: With `err_mode` high, entries whose error flag is set are corrupted as in R12. With the mode low, or the flag clear, they play cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the start sources |
| src_sel | input | 2 | Start source: 0 downscale, 1 random, 2 pulser, 3 software |
| ds_period | input | DSW | Downscale interval minus one |
| rnd_thresh | input | 8 | Random start threshold |
| pulser | input | 1 | External pulser level |
| sw_req | input | 1 | Software start pulse |
| busy_in | input | 1 | Detector busy; blocks starts |
| err_mode | input | 1 | Enables corruption of flagged entries |
| force_err | input | 1 | Corrupt the next valid sequence |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | AW | Entry being written |
| prog_kind | input | 3 | Sequence code of the entry |
| prog_err | input | 1 | Error flag of the entry |
| prog_l1 | input | L1W | Level-1 word of the entry |
| prog_l2 | input | L2W | Level-2 word of the entry |
| prog_last | input | AW | Index of the last entry played before wrapping |
| pp_o | output | 1 | Pre-pulse strobe |
| l0_o | output | 1 | Level-0 strobe |
| l1_o | output | 1 | Level-1 strobe |
| l2a_o | output | 1 | Level-2 accept strobe |
| l2r_o | output | 1 | Level-2 reject strobe |
| l1_data_o | output | L1W | Level-1 word, valid with `l1_o` |
| l2_data_o | output | L2W | Level-2 word, valid with either L2 strobe |
| drop_count_o | output | CNTW | Number of discarded starts |

## Verification
The hardest case to reach is a start request that lands in the middle of a running sequence. The bench reaches it in two ways. It issues a software request a few cycles after a start. It also runs the downscaled source at a period far shorter than one full L0-L1-L2 sequence, so most starts fall inside active sequences. In both cases the bench checks that the sequence in flight keeps its spacing, that the drop count rises, and that the pointer advanced only once. The stray-L1 corruption of sequences that carry no L1 is reached by forcing an error just before a pre-pulse-only entry.

// File: rtl/tse_pkg.sv
package tse_pkg;

    typedef enum logic [2:0] {
        SEQ_L0          = 3'd0,
        SEQ_L0_L1_ACC   = 3'd1,
        SEQ_L0_L1_REJ   = 3'd2,
        SEQ_PP          = 3'd3,
        SEQ_PP_L0       = 3'd4,
        SEQ_PP_L0_L1_ACC = 3'd5,
        SEQ_PP_L0_L1_REJ = 3'd6,
        SEQ_NONE        = 3'd7
    } seq_kind_e;

    typedef enum logic [1:0] {
        SRC_DSCALE = 2'd0,
        SRC_RANDOM = 2'd1,
        SRC_PULSER = 2'd2,
        SRC_SOFT   = 2'd3
    } start_src_e;

    typedef struct packed {
        logic valid;
        logic pp;
        logic l0;
        logic l1;
        logic acc;
    } seq_shape_t;

    function automatic seq_shape_t seq_shape(input logic [2:0] code);
        seq_shape_t s;
        s       = '0;
        s.valid = (code != SEQ_NONE);
        s.pp    = code inside {SEQ_PP, SEQ_PP_L0, SEQ_PP_L0_L1_ACC, SEQ_PP_L0_L1_REJ};
        s.l0    = code inside {SEQ_L0, SEQ_L0_L1_ACC, SEQ_L0_L1_REJ,
                               SEQ_PP_L0, SEQ_PP_L0_L1_ACC, SEQ_PP_L0_L1_REJ};
        s.l1    = code inside {SEQ_L0_L1_ACC, SEQ_L0_L1_REJ,
                               SEQ_PP_L0_L1_ACC, SEQ_PP_L0_L1_REJ};
        s.acc   = code inside {SEQ_L0_L1_ACC, SEQ_PP_L0_L1_ACC};
        return s;
    endfunction

endpackage

// File: rtl/tse_start_gen.sv
module tse_start_gen
    import tse_pkg::*;
#(
    parameter int DSW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [1:0]     src_sel,
    input  logic [DSW-1:0] ds_period,
    input  logic [7:0]     rnd_thresh,
    input  logic           pulser,
    input  logic           sw_req,
    output logic           start
);

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic [DSW-1:0] ds_cnt;
        logic [15:0]    lfsr;
        logic           pulser_q;
        logic           start;
    } sg_st_t;

    sg_st_t s_q, s_d;
    start_src_e src;
    logic fire_ds, fire_rnd, fire_pls, fb;

    assign src = start_src_e'(src_sel);

    always_comb begin
        s_d = s_q;
        fb  = s_q.lfsr[15] ^ s_q.lfsr[13] ^ s_q.lfsr[12] ^ s_q.lfsr[10];
        s_d.lfsr     = {s_q.lfsr[14:0], fb};
        s_d.pulser_q = pulser;
        fire_ds  = 1'b0;
        if (!run || src != SRC_DSCALE) begin
            s_d.ds_cnt = ds_period;
        end else if (s_q.ds_cnt == '0) begin
            fire_ds    = 1'b1;
            s_d.ds_cnt = ds_period;
        end else begin
            s_d.ds_cnt = s_q.ds_cnt - 1'b1;
        end
        fire_rnd = s_q.lfsr[7:0] < rnd_thresh;
        fire_pls = pulser & ~s_q.pulser_q;
        unique case (src)
            SRC_DSCALE: s_d.start = run & fire_ds;
            SRC_RANDOM: s_d.start = run & fire_rnd;
            SRC_PULSER: s_d.start = run & fire_pls;
            default:    s_d.start = run & sw_req;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.lfsr <= LFSR_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign start = s_q.start;

endmodule

// File: rtl/tse_prog_mem.sv
module tse_prog_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 28,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/trig_seq_emu.sv
module trig_seq_emu
    import tse_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int L1W    = 8,
    parameter int L2W    = 16,
    parameter int DSW    = 16,
    parameter int CNTW   = 16,
    parameter int L0_LAT = 48,
    parameter int L1_LAT = 260,
    parameter int L2_LAT = 3520,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [1:0]      src_sel,
    input  logic [DSW-1:0]  ds_period,
    input  logic [7:0]      rnd_thresh,
    input  logic            pulser,
    input  logic            sw_req,
    input  logic            busy_in,
    input  logic            err_mode,
    input  logic            force_err,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [2:0]      prog_kind,
    input  logic            prog_err,
    input  logic [L1W-1:0]  prog_l1,
    input  logic [L2W-1:0]  prog_l2,
    input  logic [AW-1:0]   prog_last,
    output logic            pp_o,
    output logic            l0_o,
    output logic            l1_o,
    output logic            l2a_o,
    output logic            l2r_o,
    output logic [L1W-1:0]  l1_data_o,
    output logic [L2W-1:0]  l2_data_o,
    output logic [CNTW-1:0] drop_count_o
);

    localparam int TW = $clog2(L2_LAT + 1);
    localparam int EW = 4 + L1W + L2W;

    typedef struct packed {
        logic            active;
        logic [TW-1:0]   tcnt;
        logic [TW-1:0]   endt;
        logic [AW-1:0]   ptr;
        logic            want_l0;
        logic            want_l1;
        logic            want_l2;
        logic            acc;
        logic [L1W-1:0]  l1d;
        logic [L2W-1:0]  l2d;
        logic            force_pend;
        logic [CNTW-1:0] drops;
        logic            pp;
        logic            l0;
        logic            l1;
        logic            l2a;
        logic            l2r;
        logic [L1W-1:0]  l1_out;
        logic [L2W-1:0]  l2_out;
    } emu_st_t;

    emu_st_t q, d;
    logic          start;
    logic [EW-1:0] wr_word, rd_word;
    logic          ent_err;
    logic [2:0]    ent_kind;
    logic [L1W-1:0] ent_l1;
    logic [L2W-1:0] ent_l2;
    seq_shape_t    shp;
    logic          accept, corrupt;

    tse_start_gen #(.DSW(DSW)) u_start (
        .clk(clk), .rst(rst), .run(run), .src_sel(src_sel),
        .ds_period(ds_period), .rnd_thresh(rnd_thresh),
        .pulser(pulser), .sw_req(sw_req), .start(start)
    );

    assign wr_word = {prog_err, prog_kind, prog_l1, prog_l2};

    tse_prog_mem #(.DEPTH(DEPTH), .W(EW)) u_mem (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(wr_word),
        .raddr(q.ptr), .rdata(rd_word)
    );

    assign ent_err  = rd_word[EW-1];
    assign ent_kind = rd_word[EW-2 -: 3];
    assign ent_l1   = rd_word[L2W +: L1W];
    assign ent_l2   = rd_word[L2W-1:0];

    always_comb begin
        d        = q;
        d.pp     = 1'b0;
        d.l0     = 1'b0;
        d.l1     = 1'b0;
        d.l2a    = 1'b0;
        d.l2r    = 1'b0;
        d.l1_out = '0;
        d.l2_out = '0;
        shp      = seq_shape(ent_kind);
        accept   = start && !busy_in && !q.active;
        corrupt  = q.force_pend | (err_mode & ent_err);
        d.force_pend = q.force_pend | force_err;
        if (start && !accept) d.drops = q.drops + 1'b1;

        if (q.active) begin
            d.tcnt = q.tcnt + 1'b1;
            if (q.tcnt == TW'(L0_LAT)) d.l0 = q.want_l0;
            if (q.tcnt == TW'(L1_LAT) && q.want_l1) begin
                d.l1     = 1'b1;
                d.l1_out = q.l1d;
            end
            if (q.tcnt == TW'(L2_LAT) && q.want_l2) begin
                d.l2a    = q.acc;
                d.l2r    = !q.acc;
                d.l2_out = q.l2d;
            end
            if (q.tcnt == q.endt) d.active = 1'b0;
        end else if (accept) begin
            d.ptr = (q.ptr == prog_last) ? '0 : q.ptr + 1'b1;
            if (shp.valid) begin
                d.force_pend = force_err;
                d.active     = 1'b1;
                d.tcnt       = TW'(1);
                d.pp         = shp.pp;
                d.want_l0    = shp.l0;
                d.want_l1    = shp.l1 | corrupt;
                d.want_l2    = shp.l1 & !corrupt;
                d.acc        = shp.acc;
                d.l1d        = ent_l1;
                d.l2d        = ent_l2;
                if (corrupt)     d.endt = TW'(L1_LAT);
                else if (shp.l1) d.endt = TW'(L2_LAT);
                else             d.endt = TW'(L0_LAT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pp_o         = q.pp;
    assign l0_o         = q.l0;
    assign l1_o         = q.l1;
    assign l2a_o        = q.l2a;
    assign l2r_o        = q.l2r;
    assign l1_data_o    = q.l1_out;
    assign l2_data_o    = q.l2_out;
    assign drop_count_o = q.drops;

endmodule

// File: rtl/trig_seq_emu_chk.sv
module trig_seq_emu_chk #(
    parameter int L0_LAT = 48,
    parameter int L1_LAT = 260,
    parameter int L2_LAT = 3520,
    parameter int CNTW   = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            pp_o,
    input logic            l0_o,
    input logic            l1_o,
    input logic            l2a_o,
    input logic            l2r_o,
    input logic [CNTW-1:0] drop_count_o
);

    localparam int SW = $clog2(L2_LAT + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] since_l0_q, since_l1_q;
    logic          rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            since_l0_q <= SMAX;
            since_l1_q <= SMAX;
        end else begin
            if (l0_o)                    since_l0_q <= SW'(1);
            else if (since_l0_q != SMAX) since_l0_q <= since_l0_q + 1'b1;
            if (l1_o)                    since_l1_q <= SW'(1);
            else if (since_l1_q != SMAX) since_l1_q <= since_l1_q + 1'b1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (rst_seen_q) begin
            reset_quiet_chk: assert (!(pp_o | l0_o | l1_o | l2a_o | l2r_o) && drop_count_o == '0);
        end
    end

    // R2
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pp_o, l0_o, l1_o, l2a_o, l2r_o}));

    // R3
    l2_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (l2a_o || l2r_o) |-> since_l1_q == SW'(L2_LAT - L1_LAT));

    // R10
    l1_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        l1_o |-> since_l0_q >= SW'(L1_LAT - L0_LAT));

    // R9
    drop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_count_o == $past(drop_count_o)) ||
        (drop_count_o == CNTW'($past(drop_count_o) + 1'b1)));

endmodule

bind trig_seq_emu trig_seq_emu_chk #(
    .L0_LAT(L0_LAT), .L1_LAT(L1_LAT), .L2_LAT(L2_LAT), .CNTW(CNTW)
) u_chk (
    .clk(clk), .rst(rst), .pp_o(pp_o), .l0_o(l0_o), .l1_o(l1_o),
    .l2a_o(l2a_o), .l2r_o(l2r_o), .drop_count_o(drop_count_o)
);

// File: tb/trig_seq_emu_test.sv
module trig_seq_emu_test;

    localparam int LT0 = 4;
    localparam int LT1 = 12;
    localparam int LT2 = 30;

    logic        clk = 0;
    logic        rst = 1;
    logic        run = 0;
    logic [1:0]  src_sel = 2'd3;
    logic [15:0] ds_period = 0;
    logic [7:0]  rnd_thresh = 0;
    logic        pulser = 0, sw_req = 0, busy_in = 0, err_mode = 0, force_err = 0;
    logic        prog_we = 0;
    logic [4:0]  prog_addr = 0, prog_last = 0;
    logic [2:0]  prog_kind = 0;
    logic        prog_err = 0;
    logic [7:0]  prog_l1 = 0;
    logic [15:0] prog_l2 = 0;
    logic        pp_o, l0_o, l1_o, l2a_o, l2r_o;
    logic [7:0]  l1_data_o;
    logic [15:0] l2_data_o;
    logic [15:0] drop_count_o;

    trig_seq_emu #(.L0_LAT(LT0), .L1_LAT(LT1), .L2_LAT(LT2)) uut (
        .clk(clk), .rst(rst), .run(run), .src_sel(src_sel), .ds_period(ds_period),
        .rnd_thresh(rnd_thresh), .pulser(pulser), .sw_req(sw_req), .busy_in(busy_in),
        .err_mode(err_mode), .force_err(force_err), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_kind(prog_kind), .prog_err(prog_err),
        .prog_l1(prog_l1), .prog_l2(prog_l2), .prog_last(prog_last),
        .pp_o(pp_o), .l0_o(l0_o), .l1_o(l1_o), .l2a_o(l2a_o), .l2r_o(l2r_o),
        .l1_data_o(l1_data_o), .l2_data_o(l2_data_o), .drop_count_o(drop_count_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int     kind;
        longint data;
        longint at;
        longint gap;
        string  req;
    } exp_t;

    exp_t   exp_q[$];
    longint cyc = 0;
    longint last_t = 0;
    int     seen = 0;
    bit     sb_off = 0;
    int     n_vec = 0;
    int     n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input longint data, input longint at,
                        input longint gap, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.at = at; e.gap = gap; e.req = req;
        exp_q.push_back(e);
    endtask

    // expected strobes of one sequence, from the code table of R2
    task automatic push_seq(input int k, input longint l1d, input longint l2d,
                            input bit corrupt, input longint base, input string req);
        bit has_pp, has_l0, has_l1, acc;
        has_pp = (k >= 3 && k <= 6);
        has_l0 = (k == 0 || k == 1 || k == 2 || k == 4 || k == 5 || k == 6);
        has_l1 = (k == 1 || k == 2 || k == 5 || k == 6);
        acc    = (k == 1 || k == 5);
        if (k == 7) return;
        if (has_pp) push(0, 0, base < 0 ? -1 : base, -1, req);
        if (has_l0) push(1, 0, base < 0 ? -1 : base + LT0, -1, req);
        if (has_l1 || corrupt) push(2, l1d, base < 0 ? -1 : base + LT1, -1, req);
        if (has_l1 && !corrupt) push(acc ? 3 : 4, l2d, base < 0 ? -1 : base + LT2, -1, req);
    endtask

    // monitor: pops and compares as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 5; k++) begin
                bit hit;
                exp_t e;
                case (k)
                    0: hit = pp_o;
                    1: hit = l0_o;
                    2: hit = l1_o;
                    3: hit = l2a_o;
                    default: hit = l2r_o;
                endcase
                if (hit) begin
                    seen++;
                    if (!sb_off) begin
                        if (exp_q.size() == 0) begin
                            check(0, "R2", "unexpected strobe kind", k, -1);
                        end else begin
                            e = exp_q.pop_front();
                            check(e.kind == k, e.req, "strobe kind", k, e.kind);
                            if (e.at >= 0) check(cyc == e.at, "R3", "strobe cycle", cyc, e.at);
                            if (k == 2) check(l1_data_o == e.data, "R4", "l1 data", l1_data_o, e.data);
                            if (k >= 3) check(l2_data_o == e.data, "R4", "l2 data", l2_data_o, e.data);
                            if (e.gap >= 0) check(cyc - last_t == e.gap, e.req, "strobe gap", cyc - last_t, e.gap);
                        end
                    end
                    last_t = cyc;
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic prog(input int addr, input int kind, input bit err,
                        input int l1, input int l2);
        @(negedge clk);
        prog_we = 1; prog_addr = 5'(addr); prog_kind = 3'(kind);
        prog_err = err; prog_l1 = 8'(l1); prog_l2 = 16'(l2);
        @(negedge clk);
        prog_we = 0;
    endtask

    task automatic settle(input string req);
        repeat (LT2 + 4) @(negedge clk);
        check(exp_q.size() == 0, req, "missing strobes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic play_sw(input int k, input int l1d, input int l2d,
                           input bit corrupt, input string req);
        longint t0;
        @(negedge clk);
        sw_req = 1;
        t0 = cyc;
        push_seq(k, l1d, l2d, corrupt, t0 + 2, req);
        @(negedge clk);
        sw_req = 0;
        settle(req);
    endtask

    task automatic wait_drain(input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int s0;
        longint t0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(!(pp_o | l0_o | l1_o | l2a_o | l2r_o), "R1", "strobes after reset",
              {pp_o, l0_o, l1_o, l2a_o, l2r_o}, 0);
        check(drop_count_o == 0, "R1", "drop count after reset", drop_count_o, 0);

        // R2 all codes, R1 first entry is 0, R11 wrap
        for (int i = 0; i < 8; i++) prog(i, i, 0, 8'h10 + i, 16'hA000 + i);
        prog_last = 5'd7;
        run = 1; src_sel = 2'd3;
        for (int i = 0; i < 8; i++) play_sw(i, 8'h10 + i, 16'hA000 + i, 0, "R2");
        check(drop_count_o == 0, "R2", "code 7 not a drop", drop_count_o, 0);
        play_sw(0, 8'h10, 16'hA000, 0, "R11");

        // R5 run low blocks starts and pointer stays
        run = 0;
        s0 = seen;
        @(negedge clk); sw_req = 1; @(negedge clk); sw_req = 0;
        repeat (40) @(negedge clk);
        check(seen == s0, "R5", "strobes with run low", seen, s0);
        run = 1;
        play_sw(1, 8'h11, 16'hA001, 0, "R5");

        // R9 busy drop
        do_reset();
        prog(0, 1, 0, 8'h21, 16'hB001);
        prog(1, 5, 0, 8'h22, 16'hB002);
        prog_last = 5'd1;
        busy_in = 1;
        s0 = seen;
        @(negedge clk); sw_req = 1; @(negedge clk); sw_req = 0;
        repeat (40) @(negedge clk);
        check(seen == s0, "R9", "strobes while busy", seen, s0);
        check(drop_count_o == 1, "R9", "drop count after busy", drop_count_o, 1);
        busy_in = 0;
        play_sw(1, 8'h21, 16'hB001, 0, "R9");

        // R10 start during active sequence
        do_reset();
        @(negedge clk); sw_req = 1; t0 = cyc;
        push_seq(1, 8'h21, 16'hB001, 0, t0 + 2, "R10");
        @(negedge clk); sw_req = 0;
        repeat (5) @(negedge clk);
        sw_req = 1; @(negedge clk); sw_req = 0;
        settle("R10");
        check(drop_count_o == 1, "R10", "drop count while active", drop_count_o, 1);
        play_sw(5, 8'h22, 16'hB002, 0, "R10");

        // R12 forced error
        do_reset();
        prog(0, 1, 0, 8'h31, 16'hC001);
        prog_last = 5'd0;
        @(negedge clk); force_err = 1; @(negedge clk); force_err = 0;
        play_sw(1, 8'h31, 16'hC001, 1, "R12");
        play_sw(1, 8'h31, 16'hC001, 0, "R12");
        prog(0, 3, 0, 8'h32, 16'hC002);
        @(negedge clk); force_err = 1; @(negedge clk); force_err = 0;
        play_sw(3, 8'h32, 16'hC002, 1, "R12");

        // R13 error mode with entry flag
        prog(0, 6, 1, 8'h41, 16'hD001);
        err_mode = 1;
        play_sw(6, 8'h41, 16'hD001, 1, "R13");
        err_mode = 0;
        play_sw(6, 8'h41, 16'hD001, 0, "R13");
        prog(0, 6, 0, 8'h42, 16'hD002);
        err_mode = 1;
        play_sw(6, 8'h42, 16'hD002, 0, "R13");
        err_mode = 0;

        // R6 downscaled source
        do_reset();
        prog(0, 0, 0, 0, 0);
        prog_last = 5'd0;
        src_sel = 2'd0; ds_period = 16'd29;
        push(1, 0, -1, -1, "R6");
        for (int i = 0; i < 5; i++) push(1, 0, -1, 30, "R6");
        @(negedge clk); run = 1;
        wait_drain(400);
        busy_in = 1; run = 0;
        check(exp_q.size() == 0, "R6", "downscaled starts missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (40) @(negedge clk);
        check(drop_count_o == 0, "R6", "drops with long period", drop_count_o, 0);
        busy_in = 0;

        // R10 short downscale period against long sequences
        do_reset();
        prog(0, 1, 0, 8'h3C, 16'h1234);
        ds_period = 16'd3;
        for (int i = 0; i < 3; i++) begin
            push(1, 0, -1, -1, "R10");
            push(2, 8'h3C, -1, LT1 - LT0, "R10");
            push(3, 16'h1234, -1, LT2 - LT1, "R10");
        end
        @(negedge clk); run = 1;
        wait_drain(400);
        busy_in = 1; run = 0;
        check(exp_q.size() == 0, "R10", "sequences missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (40) @(negedge clk);
        check(drop_count_o > 0, "R10", "drops under fast source", drop_count_o, 1);
        busy_in = 0;

        // R7 pulser rising edge
        do_reset();
        prog(0, 3, 0, 0, 0);
        src_sel = 2'd2; run = 1;
        @(negedge clk); pulser = 1; t0 = cyc;
        push(0, 0, t0 + 2, -1, "R7");
        repeat (40) @(negedge clk);
        pulser = 0;
        repeat (5) @(negedge clk);
        pulser = 1; t0 = cyc;
        push(0, 0, t0 + 2, -1, "R7");
        repeat (10) @(negedge clk);
        pulser = 0;
        settle("R7");

        // R8 random source
        do_reset();
        src_sel = 2'd1; rnd_thresh = 8'd0; run = 1;
        s0 = seen;
        repeat (200) @(negedge clk);
        check(seen == s0, "R8", "random starts with threshold 0", seen, s0);
        sb_off = 1;
        rnd_thresh = 8'd255;
        repeat (100) @(negedge clk);
        busy_in = 1; run = 0;
        repeat (20) @(negedge clk);
        sb_off = 0; busy_in = 0;
        check(seen > s0, "R8", "random starts with threshold 255", seen, s0 + 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule